// File: doc/BRIEF.md
# Segmented Mixed-Scheme Binary Adder

This block is a purely combinational adder. It takes two `WIDTH`-bit operands and a carry-in, and it returns a `WIDTH`-bit sum and a carry-out. The operand is cut into at most three contiguous segments, and each segment resolves its carries in a different way.

- The low segment uses two-level carry lookahead.
- The middle segment uses carry-skip blocks.
- The high segment is a plain ripple chain.

The carry-out of each segment becomes the carry-in of the segment above it. This order, from LSB to MSB, is fixed.

Each segment width is a parameter, so an integrator can trade logic depth against area for one instance without changing the interface.

- A width of zero removes that segment entirely. Its carry then passes straight through as a wire.
- A single non-zero width gives a plain adder of one scheme.

At elaboration, the configuration is rejected in two cases:

- the three widths do not add up to `WIDTH`;
- any present segment is narrower than two bits.

Top module: `hetero_adder`

## Requirements
- R1: For every legal width split, `{carryOut, sumOut}` equals `opA + opB + carryIn` computed at `WIDTH+1` bits.
- R2: With both operands zero, the outputs are sum 0 and carry-out 0 when `carryIn` is 0, and sum 1 and carry-out 0 when `carryIn` is 1.
- R3: With an all-ones operand plus a one (either through `carryIn` = 1 with `opB` = 0, or through `opB` = 1 with `carryIn` = 0), the sum is zero and the carry-out is 1.
- R4: A carry generated in the low bits and propagated through a run of propagate bits reaches the correct position even when that run crosses one or two segment boundaries.
- R5: A segment configured with width zero acts as a carry wire. Splits that leave out any one segment still give exact sums and carry-outs.
- R6: A configuration with a single non-zero segment (lookahead only, skip only, or ripple only) is an exact full-width adder.
- R7: Lookahead and skip segments whose width is not a multiple of 4 handle their final short group or block correctly.
- R8: When every propagate bit of a 4-bit skip block is 1, the carry leaving the block equals the carry entering it, which is the same value the block's internal ripple path delivers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The block has no stored state. A wrong internal carry shows up at the ports in the same evaluation as the operands that excite it: either as a sum bit flipped just above the faulty group, block or segment boundary, or as a wrong carry-out. The bench therefore targets the vectors that route a single carry across long propagate runs and segment boundaries, because a skip or lookahead term that is dropped only shows there. It applies every vector to seven width splits at once and compares each against a behavioural sum.

// File: rtl/hadd_pkg.sv
package hadd_pkg;

  localparam int GRP = 4;

  // Carries into each bit of a 4-bit group, sum-of-products form from cin.
  function automatic logic [GRP-1:0] grpCarry(input logic [GRP-1:0] g,
                                              input logic [GRP-1:0] p,
                                              input logic cin);
    logic [GRP-1:0] c;
    logic acc;
    logic prod;
    c[0] = cin;
    for (int i = 1; i < GRP; i++) begin
      acc = cin;
      for (int k = 0; k < i; k++) acc = acc & p[k];
      for (int j = 0; j < i; j++) begin
        prod = g[j];
        for (int k = j + 1; k < i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      c[i] = acc;
    end
    return c;
  endfunction

  // Group generate: a carry leaves the group with no carry entering it.
  function automatic logic grpGenerate(input logic [GRP-1:0] g,
                                       input logic [GRP-1:0] p);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < GRP; j++) begin
      prod = g[j];
      for (int k = j + 1; k < GRP; k++) prod = prod & p[k];
      acc = acc | prod;
    end
    return acc;
  endfunction

endpackage

// File: rtl/hadd_lookahead.sv
module hadd_lookahead #(
  parameter int W = 8
) (
  input  logic [W-1:0] segA,
  input  logic [W-1:0] segB,
  input  logic         segCin,
  output logic [W-1:0] segSum,
  output logic         segCout
);
  import hadd_pkg::*;

  localparam int G    = (W + GRP - 1) / GRP;
  localparam int PADW = G * GRP;

  logic [PADW-1:0] gBits;
  logic [PADW-1:0] pBits;
  logic [PADW-1:0] bitCarry;
  logic [G-1:0]    grpGen;
  logic [G-1:0]    grpProp;
  logic [G:0]      grpCin;

  // Pad bits neither generate nor stop a carry.
  always_comb begin
    gBits = '0;
    pBits = '1;
    gBits[W-1:0] = segA & segB;
    pBits[W-1:0] = segA ^ segB;
  end

  for (genvar k = 0; k < G; k++) begin : g_grp
    assign grpGen[k]  = grpGenerate(gBits[k*GRP +: GRP], pBits[k*GRP +: GRP]);
    assign grpProp[k] = &pBits[k*GRP +: GRP];
    assign bitCarry[k*GRP +: GRP] =
      grpCarry(gBits[k*GRP +: GRP], pBits[k*GRP +: GRP], grpCin[k]);
  end

  // Second lookahead level across groups.
  always_comb begin
    logic acc;
    logic prod;
    grpCin[0] = segCin;
    for (int k = 0; k < G; k++) begin
      acc = segCin;
      for (int j = 0; j <= k; j++) acc = acc & grpProp[j];
      for (int j = 0; j <= k; j++) begin
        prod = grpGen[j];
        for (int m = j + 1; m <= k; m++) prod = prod & grpProp[m];
        acc = acc | prod;
      end
      grpCin[k+1] = acc;
    end
  end

  assign segSum  = pBits[W-1:0] ^ bitCarry[W-1:0];
  assign segCout = grpCin[G];

  if (PADW > W) begin : g_pad
    logic unusedPad;
    assign unusedPad = ^bitCarry[PADW-1:W];
    // The carry seen by the first pad bit is the real carry out of the
    // short group, so it must match the second-level result.
    always_comb begin
      AST_LA_SHORT_GROUP: assert (bitCarry[W] == segCout)
        else $error("lookahead short group carry mismatch");  // R7
    end
  end

endmodule

// File: rtl/hadd_skip.sv
module hadd_skip #(
  parameter int W = 8
) (
  input  logic [W-1:0] segA,
  input  logic [W-1:0] segB,
  input  logic         segCin,
  output logic [W-1:0] segSum,
  output logic         segCout
);
  import hadd_pkg::*;

  localparam int B    = (W + GRP - 1) / GRP;
  localparam int PADW = B * GRP;

  logic [PADW-1:0] gBits;
  logic [PADW-1:0] pBits;
  logic [PADW-1:0] bitCarry;
  logic [B:0]      blkCarry;
  logic [B-1:0]    ripOut;
  logic [B-1:0]    skipAll;

  always_comb begin
    gBits = '0;
    pBits = '1;
    gBits[W-1:0] = segA & segB;
    pBits[W-1:0] = segA ^ segB;
  end

  always_comb begin
    logic c;
    logic allP;
    blkCarry[0] = segCin;
    for (int k = 0; k < B; k++) begin
      c    = blkCarry[k];
      allP = 1'b1;
      for (int i = 0; i < GRP; i++) begin
        bitCarry[k*GRP + i] = c;
        c    = gBits[k*GRP + i] | (pBits[k*GRP + i] & c);
        allP = allP & pBits[k*GRP + i];
      end
      ripOut[k]     = c;
      skipAll[k]    = allP;
      blkCarry[k+1] = allP ? blkCarry[k] : c;
    end
  end

  assign segSum  = pBits[W-1:0] ^ bitCarry[W-1:0];
  assign segCout = blkCarry[B];

  always_comb begin
    for (int k = 0; k < B; k++) begin
      AST_SKIP_AGREES: assert (!skipAll[k] || (ripOut[k] == blkCarry[k]))
        else $error("skip bypass disagrees with ripple in block %0d", k);  // R8
    end
  end

  if (PADW > W) begin : g_pad
    logic unusedPad;
    assign unusedPad = ^bitCarry[PADW-1:W];
  end

endmodule

// File: rtl/hadd_ripple.sv
module hadd_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] segA,
  input  logic [W-1:0] segB,
  input  logic         segCin,
  output logic [W-1:0] segSum,
  output logic         segCout
);

  always_comb begin
    logic c;
    c = segCin;
    for (int i = 0; i < W; i++) begin
      segSum[i] = segA[i] ^ segB[i] ^ c;
      c = (segA[i] & segB[i]) | (c & (segA[i] ^ segB[i]));
    end
    segCout = c;
  end

endmodule

// File: rtl/hetero_adder.sv
module hetero_adder #(
  parameter int WIDTH  = 128,
  parameter int LOOK_W = 64,
  parameter int SKIP_W = 32,
  parameter int RIP_W  = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int SKIP_LO = LOOK_W;
  localparam int RIP_LO  = LOOK_W + SKIP_W;
  localparam bit CFG_BAD = (LOOK_W + SKIP_W + RIP_W != WIDTH) ||
                           (LOOK_W < 0) || (SKIP_W < 0) || (RIP_W < 0) ||
                           (LOOK_W == 1) || (SKIP_W == 1) || (RIP_W == 1);

  if (CFG_BAD) begin : g_bad_cfg
    $error("segment widths must sum to WIDTH and each present one be >= 2");
  end

  logic cLook;
  logic cSkip;

  if (LOOK_W > 0) begin : g_look
    hadd_lookahead #(.W(LOOK_W)) u_look (
      .segA(opA[LOOK_W-1:0]), .segB(opB[LOOK_W-1:0]), .segCin(carryIn),
      .segSum(sumOut[LOOK_W-1:0]), .segCout(cLook));
  end else begin : g_look_wire
    assign cLook = carryIn;
  end

  if (SKIP_W > 0) begin : g_skip
    hadd_skip #(.W(SKIP_W)) u_skip (
      .segA(opA[RIP_LO-1:SKIP_LO]), .segB(opB[RIP_LO-1:SKIP_LO]),
      .segCin(cLook), .segSum(sumOut[RIP_LO-1:SKIP_LO]), .segCout(cSkip));
  end else begin : g_skip_wire
    assign cSkip = cLook;
  end

  if (RIP_W > 0) begin : g_rip
    hadd_ripple #(.W(RIP_W)) u_rip (
      .segA(opA[WIDTH-1:RIP_LO]), .segB(opB[WIDTH-1:RIP_LO]),
      .segCin(cSkip), .segSum(sumOut[WIDTH-1:RIP_LO]), .segCout(carryOut));
  end else begin : g_rip_wire
    assign carryOut = cSkip;
  end

  always_comb begin
    AST_SUM_EXACT: assert ({carryOut, sumOut} ==
                           ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("sum mismatch");  // R1
    AST_ZERO_NO_CARRY: assert (!((opA == '0) && (opB == '0)) || !carryOut)
      else $error("carry out of zero operands");  // R2
    AST_ONES_WRAP: assert (!((&opA) && (opB == '0) && carryIn) ||
                           (carryOut && (sumOut == '0)))
      else $error("all-ones plus carry did not wrap");  // R3
  end

endmodule

// File: tb/hetero_adder_bench.sv
`timescale 1ns/1ps
module hetero_adder_bench;
  localparam int N    = 128;
  localparam int NDUT = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sumV [NDUT];
  logic         coutV [NDUT];
  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  string dutTag [NDUT] = '{"R1 split 64/32/32", "R6 lookahead only",
                           "R6 skip only", "R6 ripple only",
                           "R7/R5 split 42/86/0", "R7/R5 split 0/37/91",
                           "R5 split 30/0/98"};

  hetero_adder #(.WIDTH(N), .LOOK_W(64), .SKIP_W(32), .RIP_W(32)) u_hetero_adder (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[0]), .carryOut(coutV[0]));
  hetero_adder #(.WIDTH(N), .LOOK_W(128), .SKIP_W(0), .RIP_W(0)) u_hetero_adder_la (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[1]), .carryOut(coutV[1]));
  hetero_adder #(.WIDTH(N), .LOOK_W(0), .SKIP_W(128), .RIP_W(0)) u_hetero_adder_sk (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[2]), .carryOut(coutV[2]));
  hetero_adder #(.WIDTH(N), .LOOK_W(0), .SKIP_W(0), .RIP_W(128)) u_hetero_adder_rc (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[3]), .carryOut(coutV[3]));
  hetero_adder #(.WIDTH(N), .LOOK_W(42), .SKIP_W(86), .RIP_W(0)) u_hetero_adder_ls (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[4]), .carryOut(coutV[4]));
  hetero_adder #(.WIDTH(N), .LOOK_W(0), .SKIP_W(37), .RIP_W(91)) u_hetero_adder_sr (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[5]), .carryOut(coutV[5]));
  hetero_adder #(.WIDTH(N), .LOOK_W(30), .SKIP_W(0), .RIP_W(98)) u_hetero_adder_lr (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sumV[6]), .carryOut(coutV[6]));

  function automatic logic [N-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [N-1:0] lowOnes(input int m);
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < m; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Drive on the rising edge, compare every split on the falling edge.
  task automatic apply(input logic [N-1:0] na, input logic [N-1:0] nb,
                       input logic nc, input string tag);
    logic [N:0] expect_v;
    @(posedge clk);
    a = na; b = nb; cin = nc;
    expect_v = {1'b0, na} + {1'b0, nb} + {{N{1'b0}}, nc};
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      total++;
      if ({coutV[d], sumV[d]} !== expect_v) begin
        bad++;
        $display("FAIL %s [%s] a=%h b=%h cin=%b got=%h expected=%h",
                 tag, dutTag[d], na, nb, nc, {coutV[d], sumV[d]}, expect_v);
      end
    end
  endtask

  initial begin
    logic [N-1:0] alt;
    logic [N-1:0] r;
    int bnd [8] = '{30, 31, 37, 42, 64, 79, 96, 127};

    apply('0, '0, 1'b0, "R2 zero operands, no carry");
    apply('0, '0, 1'b1, "R2 zero operands, carry in");
    apply('1, '0, 1'b1, "R3 all ones plus carry in");
    apply('1, {{(N-1){1'b0}}, 1'b1}, 1'b0, "R3 all ones plus one");
    apply('0, '1, 1'b1, "R3 swapped all ones plus carry in");

    // Propagate runs from bit 0 ending just past a segment boundary.
    foreach (bnd[i]) begin
      apply(lowOnes(bnd[i] + 1), {{(N-1){1'b0}}, 1'b1}, 1'b0, "R4 run across boundary");
      apply(lowOnes(bnd[i]), '0, 1'b1, "R4 carry-in run across boundary");
    end

    // Every bit propagates: every skip block bypasses.
    alt = {(N/2){2'b01}};
    apply(alt, ~alt, 1'b1, "R8 full propagate, carry in");
    apply(alt, ~alt, 1'b0, "R8 full propagate, no carry");
    apply(~alt, alt, 1'b1, "R8 full propagate swapped");

    // Long propagate runs with a few scattered generate bits.
    for (int t = 0; t < 100; t++) begin
      r = rnd128();
      apply(r, ~r ^ (rnd128() & rnd128() & rnd128() & rnd128()), t[0],
            "R4 mostly propagate random");
    end

    for (int t = 0; t < 400; t++) begin
      apply(rnd128(), rnd128(), $urandom_range(1, 0) == 1, "R1 random operands");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule